// File: doc/BRIEF.md
# Pattern Loop Iteration Counter

This block sits beside a memory-pattern sequencer. It decides how many times a looped stretch of pattern words runs. The sequencer marks where the loop begins and ends; the marks come from bits in the pattern words themselves. The block only counts.

Three programmed 4-bit repeat fields exist, one each for read cycles, write cycles and periodic refresh-service cycles. Each field applies to both burst and single-beat transfers of its cycle type. When the sequencer pulses loop-start, the block takes the field that matches the current cycle type and loads it into a 5-bit counter. A field value of zero stands for sixteen passes.

Each loop-end pulse consumes one pass. One cycle after that pulse, the block reports whether the sequencer should jump back to the loop start or fall through. The decision is a plain control output, not a stream: the block gives one registered decision per loop-end pulse and never applies back-pressure. The sequencer must act on the decision in the cycle it is valid.

Top module: `pattern_loop_counter`

## Requirements
- R1: After reset, `dec_valid`, `dec_branch`, `loop_active` are 0 and `iters_left` is 0.
- R2: On a `loop_start` pulse, the field selected by `cyc_kind` is loaded and shows on `iters_left` the next cycle. The encoding is 2'b00 = read field, 2'b01 = write field, 2'b10 = service field, and 2'b11 = service field.
- R3: A field value of 1 to 15 gives that many passes, and a field value of 0 gives 16 passes (`iters_left` = 16 after the load).
- R4: A `loop_end` pulse during an active loop lowers `iters_left` by one. One cycle after the pulse, `dec_valid` is 1 and `dec_branch` is 1 if passes remain, or 0 on the last pass. The last pass also clears `loop_active`.
- R5: Changes to `cyc_kind` or to any count field after the load have no effect on the running loop.
- R6: A `loop_end` pulse with no active loop yields `dec_valid` = 1 with `dec_branch` = 0, and `iters_left` stays 0.
- R7: When `loop_start` and `loop_end` arrive in the same cycle, the load happens first and that end pulse then consumes one pass of the new count.
- R8: A `loop_start` during an active loop abandons the old count and reloads from the current fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_count | input | 4 | Repeat field for read cycles (0 = 16) |
| wr_count | input | 4 | Repeat field for write cycles (0 = 16) |
| svc_count | input | 4 | Repeat field for refresh-service cycles (0 = 16) |
| cyc_kind | input | 2 | Cycle type: 00 read, 01 write, 1x service |
| loop_start | input | 1 | One-cycle pulse: pattern enters the loop |
| loop_end | input | 1 | One-cycle pulse: loop-end marker reached |
| dec_valid | output | 1 | Decision valid, one cycle after `loop_end` |
| dec_branch | output | 1 | 1 = jump back to loop start, 0 = fall through |
| loop_active | output | 1 | A loop is in progress |
| iters_left | output | 5 | Passes still to run |

## Verification
The assertions assume that `loop_start` and `loop_end` are single-cycle strobes sampled on the clock edge, and that they may coincide. They also assume that the count fields are free to change at any time. The stimulus drives every strobe for exactly one cycle, starting on the falling edge. It changes the fields and the cycle type in the middle of a loop only to show that the running loop ignores them. It deliberately issues end pulses after a loop has finished, a start and an end together, and a restart during a live loop, so that each strobe combination the properties cover actually occurs.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_SVC   = 2'b10,
    KIND_SVC2  = 2'b11
  } cyc_kind_e;

  localparam int unsigned NKIND = 3;

  // Widen a field to counter width; zero encodes the maximum count.
  function automatic logic [4:0] widen4(input logic [3:0] f);
    return (f == 4'd0) ? 5'd16 : {1'b0, f};
  endfunction
endpackage

// File: rtl/plc_count_select.sv
module plc_count_select
  import plc_pkg::*;
#(
  parameter int FW = 4,
  localparam int CW = FW + 1
) (
  input  logic [FW-1:0] fields [NKIND],
  input  logic [1:0]    kind,
  output logic [CW-1:0] sel_val
);
  logic [CW-1:0] widened [NKIND];

  genvar gi;
  generate
    for (gi = 0; gi < NKIND; gi++) begin : g_widen
      assign widened[gi] = (fields[gi] == '0) ? CW'(1 << FW) : {1'b0, fields[gi]};
    end
  endgenerate

  always_comb begin
    unique case (cyc_kind_e'(kind))
      KIND_READ:  sel_val = widened[0];
      KIND_WRITE: sel_val = widened[1];
      default:    sel_val = widened[2];
    endcase
  end

  always_comb begin
    a_sel_nonzero_r3: assert (sel_val != '0);
  end
endmodule

// File: rtl/plc_iter_counter.sv
module plc_iter_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] iters_left,
  output logic          loop_active,
  output logic          step_branch
);
  logic [CW-1:0] base_cnt;
  logic          base_act;
  logic [CW-1:0] after_cnt;

  assign base_cnt  = load ? load_val : iters_left;
  assign base_act  = load | loop_active;
  assign after_cnt = base_cnt - CW'(1);
  assign step_branch = step && base_act && (after_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iters_left  <= '0;
      loop_active <= 1'b0;
    end else if (step && base_act) begin
      iters_left  <= after_cnt;
      loop_active <= (after_cnt != '0);
    end else if (load) begin
      iters_left  <= load_val;
      loop_active <= 1'b1;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(iters_left) && $stable(loop_active));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && step && !load) |=> iters_left == $past(iters_left) - CW'(1));
  p_idle_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_active && step && !load) |=> (iters_left == '0) && !loop_active);
  p_active_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_active |-> iters_left != '0);
endmodule

// File: rtl/plc_decision_reg.sv
module plc_decision_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic step_branch,
  output logic dec_valid,
  output logic dec_branch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_branch <= 1'b0;
    end else begin
      dec_valid  <= step;
      dec_branch <= step_branch;
    end
  end

  p_one_dec_per_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> dec_valid);
  p_no_spurious_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !dec_valid && !dec_branch);
endmodule

// File: rtl/pattern_loop_counter.sv
module pattern_loop_counter
  import plc_pkg::*;
#(
  parameter int FW = 4,
  localparam int CW = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] rd_count,
  input  logic [FW-1:0] wr_count,
  input  logic [FW-1:0] svc_count,
  input  logic [1:0]    cyc_kind,
  input  logic          loop_start,
  input  logic          loop_end,
  output logic          dec_valid,
  output logic          dec_branch,
  output logic          loop_active,
  output logic [CW-1:0] iters_left
);
  logic [FW-1:0] fields [NKIND];
  logic [CW-1:0] sel_val;
  logic          step_branch;

  assign fields[0] = rd_count;
  assign fields[1] = wr_count;
  assign fields[2] = svc_count;

  plc_count_select #(.FW(FW)) u_sel (
    .fields (fields),
    .kind   (cyc_kind),
    .sel_val(sel_val)
  );

  plc_iter_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (loop_start),
    .load_val   (sel_val),
    .step       (loop_end),
    .iters_left (iters_left),
    .loop_active(loop_active),
    .step_branch(step_branch)
  );

  plc_decision_reg u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (loop_end),
    .step_branch(step_branch),
    .dec_valid  (dec_valid),
    .dec_branch (dec_branch)
  );

  p_branch_matches_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_branch == (iters_left != '0));
  p_load_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_start && !loop_end) |=> loop_active && (iters_left != '0) && (iters_left <= CW'(1 << FW)));
  p_branch_keeps_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_branch) |-> loop_active);
endmodule

// File: tb/pattern_loop_counter_tb_top.sv
module pattern_loop_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rd_count = 4'd0, wr_count = 4'd0, svc_count = 4'd0;
  logic [1:0] cyc_kind = 2'b00;
  logic       loop_start = 1'b0, loop_end = 1'b0;
  logic       dec_valid, dec_branch, loop_active;
  logic [4:0] iters_left;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pattern_loop_counter dut_i (
    .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
    .svc_count(svc_count), .cyc_kind(cyc_kind), .loop_start(loop_start),
    .loop_end(loop_end), .dec_valid(dec_valid), .dec_branch(dec_branch),
    .loop_active(loop_active), .iters_left(iters_left)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected decision per valid decision.
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R4 actual=unexpected decision expected=none");
      end else begin
        check(tag_q.pop_front(), dec_branch, exp_q.pop_front());
      end
    end
  end

  task automatic do_start(input logic [1:0] k, input int exp_left, input string req);
    @(negedge clk);
    cyc_kind = k; loop_start = 1'b1;
    @(negedge clk);
    loop_start = 1'b0;
    check(req, iters_left, exp_left);
  endtask

  task automatic do_end(input bit exp, input string req);
    @(negedge clk);
    loop_end = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    loop_end = 1'b0;
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", dec_valid, 0);
    check("R1 active", loop_active, 0);
    check("R1 left", iters_left, 0);

    // R2 read field, 3 passes
    rd_count = 4'd3; wr_count = 4'd0; svc_count = 4'd1;
    do_start(2'b00, 3, "R2 read load");
    do_end(1, "R4 pass1"); do_end(1, "R4 pass2"); do_end(0, "R4 last");
    check("R4 active cleared", loop_active, 0);
    // R6 stray end
    do_end(0, "R6 stray end");
    check("R6 left stays 0", iters_left, 0);

    // R3 write field 0 -> 16 passes
    do_start(2'b01, 16, "R3 zero is 16");
    for (int i = 1; i <= 16; i++) do_end(i < 16, "R3 sixteen passes");
    check("R3 done", loop_active, 0);

    // R2 service via both encodings
    do_start(2'b10, 1, "R2 svc 10");
    do_end(0, "R3 one pass");
    svc_count = 4'd15;
    do_start(2'b11, 15, "R2 svc 11");
    for (int i = 1; i <= 15; i++) do_end(i < 15, "R3 fifteen passes");

    // R5 changes after load ignored
    rd_count = 4'd2;
    do_start(2'b00, 2, "R5 load");
    rd_count = 4'd9; wr_count = 4'd7; svc_count = 4'd5; cyc_kind = 2'b01;
    @(negedge clk);
    check("R5 left unchanged", iters_left, 2);
    do_end(1, "R5 pass1"); do_end(0, "R5 last");

    // R7 start and end together
    wr_count = 4'd2;
    @(negedge clk);
    cyc_kind = 2'b01; loop_start = 1'b1; loop_end = 1'b1;
    exp_q.push_back(1); tag_q.push_back("R7 same-cycle branch");
    @(negedge clk);
    loop_start = 1'b0; loop_end = 1'b0;
    check("R7 left after", iters_left, 1);
    do_end(0, "R7 last");

    // R8 restart mid-loop
    rd_count = 4'd4;
    do_start(2'b00, 4, "R8 first load");
    do_end(1, "R8 pass1");
    rd_count = 4'd2;
    do_start(2'b00, 2, "R8 reload");
    do_end(1, "R8 pass after reload"); do_end(0, "R8 last");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule